// File: doc/BRIEF.md
# Three-Phase PWM Output Steering and Chopping Stage

This block sits between a three-phase PWM timing generator and the six gate-drive pins. It receives three complementary raw PWM pairs and produces three high/low pin pairs: A, B and C. For each channel it can swap the pair, so that the channel's active signal drives either the high-side pin or the low-side pin. Each of the six pins has its own disable bit, which forces that pin to its inactive (low) level. The block also generates a high-frequency chopping carrier with 50% duty. The carrier can be ANDed onto all high-side pins, onto all low-side pins, or onto both. This is used with pulse-transformer gate drivers.

The steering/enable word and the chopping word are registered on the clock edge after they are presented, so software writes cannot change the pin logic between edges. The pins are driven from a register, so nothing combinational reaches them and control changes cannot cause glitches.

Top module: `pwm_steer_chop`

## Requirements
- R1: While reset is asserted (rst_ni low), all six pins are low.
- R2: Pin vector bit order is 0=AH, 1=AL, 2=BH, 3=BL, 4=CH, 5=CL, and the raw input vector uses the same order. With no crossover, no disable and no chopping, each pin equals its raw input as sampled at the previous clock edge.
- R3: Steering bits 6, 7 and 8 select crossover for channels C, B and A respectively. On a crossed channel, the high pin carries that channel's raw low input and the low pin carries its raw high input.
- R4: Steering bits 0 to 5 disable the pin with the same index (1 = disabled). A disabled pin is low whatever the raw inputs, crossover and chopping would produce.
- R5: Chopping bit 8 ANDs the carrier onto AH, BH and CH. Chopping bit 9 ANDs it onto AL, BL and CL. This happens after crossover.
- R6: Chopping bits 7:0 hold a divider D. The carrier has a period of 4*(D+1) clock cycles with equal high and low times. After reset it starts high.
- R7: A steering or chopping word presented before clock edge k governs the pins updated at edge k+1. A raw input presented before edge k appears on the pins after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_raw_i | input | 6 | Raw PWM pairs from the timing unit (bit 0=A high ... bit 5=C low) |
| steer_cfg_i | input | 9 | Per-pin disable bits [5:0], crossover bits for C/B/A at [6]/[7]/[8] |
| chop_cfg_i | input | 10 | Divider [7:0], high-side chop enable [8], low-side chop enable [9] |
| pins_o | output | 6 | Final gate-drive pins AH, AL, BH, BL, CH, CL |

## Verification
A raw input change reaches the pins after one clock edge. A steering or chopping word needs two edges: one to capture it and one to apply it to the pin register. The carrier phase advances once per edge, using the divider that was captured earlier. The bench drives every input just after a falling edge and then waits one rising edge. At that point a reference model advances, applying the previously captured configuration and carrier phase in the order set by R7. The pins are compared at the next falling edge. A separate window count of high cycles checks the carrier duty and period without relying on the model.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    // Width of the chopping carrier divider field.
    localparam int unsigned CHOP_DIV_W = 8;
    // Full chopping word: divider plus the two side enables.
    localparam int unsigned CHOP_CFG_W = CHOP_DIV_W + 2;

    // Chopping word layout: [9] low-side enable, [8] high-side enable, [7:0] divider.
    typedef struct packed {
        logic                  lo_en;
        logic                  hi_en;
        logic [CHOP_DIV_W-1:0] div;
    } chop_cfg_t;

endpackage

// File: rtl/pwm_chop_carrier.sv
module pwm_chop_carrier #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    output logic             carrier_o
);

    localparam int unsigned CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             car;
    } car_state_t;

    car_state_t st_d, st_q;
    logic [CNT_W-1:0] half_lim;

    // Each half period lasts 2*(div+1) cycles.
    assign half_lim = {div_i, 1'b1};

    always_comb begin
        st_d = st_q;
        if (st_q.cnt >= half_lim) begin
            st_d.cnt = '0;
            st_d.car = ~st_q.car;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
            st_q.car <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign carrier_o = st_q.car;

endmodule

// File: rtl/pwm_pair_route.sv
module pwm_pair_route (
    input  logic raw_hi_i,
    input  logic raw_lo_i,
    input  logic cross_i,
    input  logic dis_hi_i,
    input  logic dis_lo_i,
    input  logic chop_hi_i,
    input  logic chop_lo_i,
    input  logic carrier_i,
    output logic hi_o,
    output logic lo_o
);

    logic sel_hi, sel_lo;
    logic gate_hi, gate_lo;

    always_comb begin
        // Crossover swaps the pair.
        sel_hi  = cross_i ? raw_lo_i : raw_hi_i;
        sel_lo  = cross_i ? raw_hi_i : raw_lo_i;
        // Carrier is ANDed on the pin side, after steering.
        gate_hi = sel_hi & (carrier_i | ~chop_hi_i);
        gate_lo = sel_lo & (carrier_i | ~chop_lo_i);
        // Disable dominates everything.
        hi_o    = gate_hi & ~dis_hi_i;
        lo_o    = gate_lo & ~dis_lo_i;
    end

endmodule

// File: rtl/pwm_steer_chop.sv
module pwm_steer_chop
    import pwm_steer_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [2*NUM_CH-1:0]     pwm_raw_i,
    input  logic [3*NUM_CH-1:0]     steer_cfg_i,
    input  logic [CHOP_CFG_W-1:0]   chop_cfg_i,
    output logic [2*NUM_CH-1:0]     pins_o
);

    localparam int unsigned NPIN    = 2 * NUM_CH;
    localparam int unsigned STEER_W = 3 * NUM_CH;

    typedef struct packed {
        logic [STEER_W-1:0] steer;
        chop_cfg_t          chop;
        logic [NPIN-1:0]    pins;
    } state_t;

    state_t state_d, state_q;

    logic               carrier;
    logic [NPIN-1:0]    routed;
    logic [STEER_W-1:0] steer_q;
    logic               chop_hi_q;
    logic               chop_lo_q;

    assign steer_q   = state_q.steer;
    assign chop_hi_q = state_q.chop.hi_en;
    assign chop_lo_q = state_q.chop.lo_en;

    pwm_chop_carrier #(
        .DIV_W (CHOP_DIV_W)
    ) u_carrier (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_i     (state_q.chop.div),
        .carrier_o (carrier)
    );

    // One routing slice per channel; crossover bits run from the last
    // channel at the lowest crossover index up to the first channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_pair_route u_route (
            .raw_hi_i  (pwm_raw_i[2*c]),
            .raw_lo_i  (pwm_raw_i[2*c+1]),
            .cross_i   (state_q.steer[NPIN + NUM_CH - 1 - c]),
            .dis_hi_i  (state_q.steer[2*c]),
            .dis_lo_i  (state_q.steer[2*c+1]),
            .chop_hi_i (state_q.chop.hi_en),
            .chop_lo_i (state_q.chop.lo_en),
            .carrier_i (carrier),
            .hi_o      (routed[2*c]),
            .lo_o      (routed[2*c+1])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.steer = steer_cfg_i;
        state_d.chop  = chop_cfg_t'(chop_cfg_i);
        state_d.pins  = routed;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pins_o = state_q.pins;

endmodule

// File: rtl/pwm_steer_chop_chk.sv
module pwm_steer_chop_chk #(
    parameter int unsigned NUM_CH = 3
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [2*NUM_CH-1:0]   pwm_raw_i,
    input logic [3*NUM_CH-1:0]   steer_q,
    input logic                  chop_hi_q,
    input logic                  chop_lo_q,
    input logic                  carrier,
    input logic [2*NUM_CH-1:0]   pins_o
);

    localparam int unsigned NPIN = 2 * NUM_CH;

    // R2: plain pass-through one edge later.
    a_r2_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (steer_q == '0 && !chop_hi_q && !chop_lo_q) |=> pins_o == $past(pwm_raw_i));

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        // R4: a disabled pin stays low.
        a_r4_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
            steer_q[p] |=> !pins_o[p]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R3: crossed pair is swapped.
        a_r3_cross_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (steer_q[NPIN + NUM_CH - 1 - c] && !steer_q[2*c] && !steer_q[2*c+1]
             && !chop_hi_q && !chop_lo_q)
            |=> (pins_o[2*c] == $past(pwm_raw_i[2*c+1]) && pins_o[2*c+1] == $past(pwm_raw_i[2*c])));
        // R5: chopped high side is low while the carrier is low.
        a_r5_chop_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (chop_hi_q && !carrier) |=> !pins_o[2*c]);
        // R5: chopped low side is low while the carrier is low.
        a_r5_chop_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (chop_lo_q && !carrier) |=> !pins_o[2*c+1]);
    end

endmodule

bind pwm_steer_chop pwm_steer_chop_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwm_raw_i (pwm_raw_i),
    .steer_q   (steer_q),
    .chop_hi_q (chop_hi_q),
    .chop_lo_q (chop_lo_q),
    .carrier   (carrier),
    .pins_o    (pins_o)
);

// File: tb/pwm_steer_chop_bench.sv
module pwm_steer_chop_bench;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [5:0] pwm_raw_i = '0;
    logic [8:0] steer_cfg_i = '0;
    logic [9:0] chop_cfg_i = '0;
    logic [5:0] pins_o;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;

    // Reference model state
    logic [8:0] m_steer;
    logic [9:0] m_chop;
    logic       m_car;
    logic [8:0] m_cnt;
    logic [5:0] m_pins;

    always #5 clk_i = ~clk_i;

    pwm_steer_chop u_pwm_steer_chop (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pwm_raw_i   (pwm_raw_i),
        .steer_cfg_i (steer_cfg_i),
        .chop_cfg_i  (chop_cfg_i),
        .pins_o      (pins_o)
    );

    // Expected pins from R2..R5: bit 0 AH .. bit 5 CL, crossover A/B/C at 8/7/6,
    // chop high enable bit 8, low enable bit 9.
    function automatic logic [5:0] exp_pins(input logic [5:0] raw, input logic [8:0] st,
                                            input logic [9:0] ch, input logic car);
        logic [5:0] r;
        for (int c = 0; c < 3; c++) begin
            logic x, hi, lo;
            x  = st[8 - c];
            hi = x ? raw[2*c+1] : raw[2*c];
            lo = x ? raw[2*c]   : raw[2*c+1];
            if (ch[8]) hi = hi & car;
            if (ch[9]) lo = lo & car;
            if (st[2*c])   hi = 1'b0;
            if (st[2*c+1]) lo = 1'b0;
            r[2*c]   = hi;
            r[2*c+1] = lo;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: pins actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive after a falling edge, advance the model at the rising edge, compare at the next falling edge.
    task automatic step(input logic [5:0] raw, input logic [8:0] st, input logic [9:0] ch,
                        input string req);
        logic [8:0] lim;
        pwm_raw_i   = raw;
        steer_cfg_i = st;
        chop_cfg_i  = ch;
        @(posedge clk_i);
        m_pins = exp_pins(raw, m_steer, m_chop, m_car);
        lim = {m_chop[7:0], 1'b1};
        if (m_cnt >= lim) begin
            m_cnt = '0;
            m_car = ~m_car;
        end else begin
            m_cnt = m_cnt + 1'b1;
        end
        m_steer = st;
        m_chop  = ch;
        @(negedge clk_i);
        check(req, pins_o, m_pins);
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        int unsigned ones;
        logic [8:0] rs;
        logic [9:0] rc;
        seed = 32'd24681357;
        void'($urandom(seed));

        // R1: reset holds pins low even with active inputs
        pwm_raw_i = 6'h3F;
        repeat (3) @(negedge clk_i);
        check("R1", pins_o, 6'b0);
        m_steer = '0; m_chop = '0; m_car = 1'b1; m_cnt = '0; m_pins = '0;
        rst_ni = 1'b1;

        // R2: walking ones and zeros, plain pass-through
        for (int i = 0; i < 6; i++) step(6'b1 << i, 9'h0, 10'h0, "R2");
        for (int i = 0; i < 6; i++) step(~(6'b1 << i), 9'h0, 10'h0, "R2");

        // R3: crossover on each channel in turn, then all
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 4; k++) step(6'b010101 ^ (6'(k) << (2*c)), 9'h100 >> c, 10'h0, "R3");
        end
        for (int k = 0; k < 4; k++) step(k[0] ? 6'b101010 : 6'b010101, 9'h1C0, 10'h0, "R3");

        // R4: each pin disabled while crossover and chopping are also active
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 3; k++) step(6'h3F, 9'h1C0 | (9'h1 << p), 10'h300, "R4");
        end

        // R7: steering change applies one edge after capture
        step(6'h3F, 9'h000, 10'h000, "R7");
        step(6'h3F, 9'h000, 10'h000, "R7");
        step(6'h3F, 9'h03F, 10'h000, "R7");
        check("R7", pins_o, 6'h3F);
        step(6'h3F, 9'h03F, 10'h000, "R7");
        check("R7", pins_o, 6'h00);

        // R5: high-side chop, low-side chop, both
        for (int k = 0; k < 16; k++) step(6'h3F, 9'h0, 10'h101, "R5");
        for (int k = 0; k < 16; k++) step(6'h3F, 9'h0, 10'h201, "R5");
        for (int k = 0; k < 16; k++) step(6'h3F, 9'h0, 10'h300, "R5");

        // R6: with D=2 any 24-cycle window holds 12 carrier-high cycles
        for (int k = 0; k < 30; k++) step(6'h3F, 9'h0, 10'h102, "R6");
        ones = 0;
        for (int k = 0; k < 24; k++) begin
            step(6'h3F, 9'h0, 10'h102, "R6");
            if (pins_o[0]) ones++;
        end
        n_checks++;
        if (ones != 12) begin
            n_errors++;
            $display("FAIL R6: high cycles actual=%0d expected=12", ones);
        end
        // R6: largest divider for a few periods
        for (int k = 0; k < 2100; k++) step(6'h3F, 9'h0, 10'h1FF, "R6");

        // R7: random raw inputs with occasional configuration changes
        rs = '0; rc = '0;
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 15) == 0) rs = 9'($urandom);
            if ($urandom_range(0, 31) == 0) rc = {2'($urandom), 8'($urandom_range(0, 5))};
            step(6'($urandom), rs, rc, "R7");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule